// File: doc/BRIEF.md
# Dual-Mode Alert Output Controller

This block watches three measurement channels (temperature, current and voltage) and drives an active-low alert line of the kind that is wired to an open-drain pad. Each channel has a high and a low limit. A new reading arrives with a one-cycle strobe. For every channel the block keeps a high-fault status bit and a low-fault status bit. Software reads these bits and acknowledges them with a clear strobe.

A mode input picks how high-limit faults are handled. In the latched interrupt mode, a reading strictly outside a limit sets a sticky status bit, and the alert stays asserted until that bit is acknowledged. In the hysteretic comparator mode, a reading at or above the high limit makes the high fault active. The fault stays active until a reading falls below the high limit minus a hysteresis value. The status bit follows this active state and cannot be cleared by software. Low-limit faults always use the latched behaviour, whatever the mode. Temperature faults in the latched path need a run of consecutive out-of-limit readings before they count. In comparator mode, a linked peak-current event can also drive the alert.

Top module: `alert_ctrl`

## Requirements
- R1: After reset, `alert_no` is 1 and `status_o` is 0. Status bit layout: bit0 temperature high, bit1 temperature low, bit2 current high, bit3 current low, bit4 voltage high, bit5 voltage low. A reading sampled with `meas_valid_i` updates `status_o` after that same clock edge. `alert_no` follows one clock later.
- R2: A latched temperature fault needs a reading strictly above the high limit or strictly below the low limit. It sets its status bit only on the N-th consecutive faulty reading. N is 1, 2, 4 or 8 for `queue_sel_i` values 0, 1, 2 and 3. Any in-limit temperature reading resets the run.
- R3: In interrupt mode, a current or voltage reading strictly above its high limit, or strictly below its low limit, sets the matching status bit and asserts the alert. A reading equal to a limit does neither.
- R4: Latched status bits are sticky. A clear strobe drops only the bits whose fault was absent in the most recent reading. The alert stays asserted while any unmasked latched bit remains.
- R5: While `mask_all_i` is 1, latched sources cannot assert the alert, but the latched status bits still update. Once the mask drops, any pending latched bit asserts the alert again.
- R6: In interrupt mode, `peak_i` never asserts the alert, even when `peak_link_i` is 1.
- R7: In comparator mode, temperature high becomes active when a reading is at or above `temp_hi_i`. It releases only when a reading is strictly below `temp_hi_i - temp_hyst_i` (saturating at 0). The temperature high path in this mode uses no consecutive-reading queue.
- R8: In comparator mode, current and voltage high faults become active at or above their high limits. They release strictly below the high limit minus `cv_hyst_i`.
- R9: In comparator mode, each high status bit equals its active state. A clear strobe does not clear it, and it clears by itself on release.
- R10: In comparator mode, `mask_all_i` does not block high or peak events. In both modes, `evt_mask_i` bits 0, 1 and 2 block the temperature, current and voltage channels from the alert, and bit 3 blocks peak events. Masked channels still update their status.
- R11: Low-limit faults stay latched in comparator mode. They are cleared only by the clear strobe, and `mask_all_i` blocks them from the alert.
- R12: In comparator mode, with `peak_link_i` at 1 and `evt_mask_i[3]` at 0, a high `peak_i` asserts the alert one clock later. The alert releases once the peak or the link drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| meas_valid_i | input | 1 | One-cycle strobe for a new set of readings |
| temp_i | input | W | Temperature reading |
| curr_i | input | W | Current reading |
| volt_i | input | W | Voltage reading |
| temp_hi_i | input | W | Temperature high limit |
| temp_lo_i | input | W | Temperature low limit |
| curr_hi_i | input | W | Current high limit |
| curr_lo_i | input | W | Current low limit |
| volt_hi_i | input | W | Voltage high limit |
| volt_lo_i | input | W | Voltage low limit |
| temp_hyst_i | input | W | Temperature comparator hysteresis |
| cv_hyst_i | input | W | Current/voltage comparator hysteresis |
| comp_mode_i | input | 1 | 1 = comparator mode for high events, 0 = interrupt mode |
| mask_all_i | input | 1 | Global mask for latched sources |
| evt_mask_i | input | 4 | Per-event masks: temp, curr, volt, peak |
| queue_sel_i | input | 2 | Consecutive-reading depth select |
| status_clr_i | input | 1 | Status read/acknowledge strobe |
| peak_i | input | 1 | Peak-current detect level |
| peak_link_i | input | 1 | Links peak events to the alert |
| alert_no | output | 1 | Active-low alert level |
| status_o | output | 6 | Status bits |

## Verification
The bench probes each limit at its edge value. Equal readings must not trip a strict compare, and a release exactly at the hysteresis threshold must not drop the comparator. A design with an off-by-one in either compare would flag or release one step early. The bench breaks a temperature run with a single in-limit reading, so a queue that never resets would assert early. It also acknowledges a fault that is still present, so a design that clears unconditionally would drop an active alert. Further checks confirm that reads cannot clear comparator status bits, that the global mask stops low faults but not comparator faults, and that peak events count only in comparator mode with the link enabled.

// File: rtl/alert_pkg.sv
package alert_pkg;
  localparam int unsigned NCH = 3;
  localparam int unsigned SW  = 2 * NCH;

  typedef enum logic [1:0] {
    CH_TEMP = 2'd0,
    CH_CURR = 2'd1,
    CH_VOLT = 2'd2
  } ch_e;

  // queue depth decode: 0..3 -> 1,2,4,8
  function automatic logic [4:0] q_depth(input logic [1:0] sel);
    return 5'd1 << sel;
  endfunction
endpackage

// File: rtl/alert_fault_queue.sv
module alert_fault_queue
  import alert_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       meas_i,
  input  logic       fault_i,
  input  logic [1:0] sel_i,
  output logic       full_o
);
  logic [3:0] cnt_q;
  logic [4:0] cnt_inc;
  logic [4:0] depth;

  assign depth   = q_depth(sel_i);
  assign cnt_inc = {1'b0, cnt_q} + 5'd1;
  assign full_o  = fault_i && (cnt_inc >= depth);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (meas_i) begin
      if (!fault_i)            cnt_q <= '0;
      else if (cnt_q < 4'd8)   cnt_q <= cnt_inc[3:0];
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8);
  a_r2_reset_on_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_i && !fault_i |=> cnt_q == 4'd0);
endmodule

// File: rtl/alert_hyst_trk.sv
module alert_hyst_trk #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         meas_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] hyst_i,
  output logic         act_o
);
  logic [W-1:0] thr;
  logic         act_q;

  assign thr   = (hi_i > hyst_i) ? (hi_i - hyst_i) : '0;
  assign act_o = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      act_q <= 1'b0;
    else if (meas_i && val_i >= hi_i) act_q <= 1'b1;
    else if (meas_i && val_i < thr)   act_q <= 1'b0;
  end

  a_r7_rise_at_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> $past(meas_i && (val_i >= hi_i)));
  a_r8_fall_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> $past(meas_i && (val_i < hi_i)));
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import alert_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         meas_valid_i,
  input  logic [W-1:0] temp_i,
  input  logic [W-1:0] curr_i,
  input  logic [W-1:0] volt_i,
  input  logic [W-1:0] temp_hi_i,
  input  logic [W-1:0] temp_lo_i,
  input  logic [W-1:0] curr_hi_i,
  input  logic [W-1:0] curr_lo_i,
  input  logic [W-1:0] volt_hi_i,
  input  logic [W-1:0] volt_lo_i,
  input  logic [W-1:0] temp_hyst_i,
  input  logic [W-1:0] cv_hyst_i,
  input  logic         comp_mode_i,
  input  logic         mask_all_i,
  input  logic [3:0]   evt_mask_i,
  input  logic [1:0]   queue_sel_i,
  input  logic         status_clr_i,
  input  logic         peak_i,
  input  logic         peak_link_i,
  output logic         alert_no,
  output logic [5:0]   status_o
);
  logic [NCH-1:0][W-1:0] val, hi, lo, hyst;
  logic [NCH-1:0]        above, below, cmp_act, ch_en;
  logic [NCH-1:0]        lat_hi, lat_lo;
  logic [SW-1:0]         set_v, flt_q, lat_q, lat_d;
  logic                  temp_full;
  logic                  lat_src, cmp_src, pk_src, alert_d;

  assign val  = {volt_i, curr_i, temp_i};
  assign hi   = {volt_hi_i, curr_hi_i, temp_hi_i};
  assign lo   = {volt_lo_i, curr_lo_i, temp_lo_i};
  assign hyst = {cv_hyst_i, cv_hyst_i, temp_hyst_i};
  assign ch_en = ~evt_mask_i[NCH-1:0];

  alert_fault_queue u_tq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .meas_i (meas_valid_i),
    .fault_i(above[CH_TEMP] | below[CH_TEMP]),
    .sel_i  (queue_sel_i),
    .full_o (temp_full)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign above[c] = val[c] > hi[c];
    assign below[c] = val[c] < lo[c];

    if (c == CH_TEMP) begin : g_q
      assign set_v[2*c]   = above[c] & temp_full;
      assign set_v[2*c+1] = below[c] & temp_full;
    end else begin : g_nq
      assign set_v[2*c]   = above[c];
      assign set_v[2*c+1] = below[c];
    end

    alert_hyst_trk #(.W(W)) u_hy (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .meas_i (meas_valid_i),
      .val_i  (val[c]),
      .hi_i   (hi[c]),
      .hyst_i (hyst[c]),
      .act_o  (cmp_act[c])
    );

    assign lat_hi[c]       = lat_q[2*c];
    assign lat_lo[c]       = lat_q[2*c+1];
    assign status_o[2*c]   = comp_mode_i ? cmp_act[c] : lat_q[2*c];
    assign status_o[2*c+1] = lat_q[2*c+1];
  end

  // clear keeps bits whose fault was present in the latest reading
  always_comb begin
    lat_d = status_clr_i ? flt_q : lat_q;
    if (meas_valid_i) lat_d = lat_d | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= '0;
      lat_q <= '0;
    end else begin
      lat_q <= lat_d;
      if (meas_valid_i) flt_q <= set_v;
    end
  end

  assign lat_src = ((|(lat_hi & ch_en)) & ~comp_mode_i) | (|(lat_lo & ch_en));
  assign cmp_src = comp_mode_i & (|(cmp_act & ch_en));
  assign pk_src  = comp_mode_i & peak_link_i & peak_i & ~evt_mask_i[3];
  assign alert_d = (lat_src & ~mask_all_i) | cmp_src | pk_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_no <= 1'b1;
    else         alert_no <= ~alert_d;
  end

  a_r5_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comp_mode_i && mask_all_i |=> alert_no);
  a_r6_peak_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comp_mode_i && (lat_q == '0) |=> alert_no);
  a_r12_peak_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_mode_i && peak_link_i && peak_i && !evt_mask_i[3] |=> !alert_no);
  a_r9_no_read_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_mode_i && !meas_valid_i && status_o[0] |=> status_o[0] || !comp_mode_i);
endmodule

// File: tb/alert_ctrl_tb_top.sv
`timescale 1ns/1ps
module alert_ctrl_tb_top;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic meas = 0;
  logic [W-1:0] t = 40, c = 50, v = 100;
  logic [W-1:0] t_hi = 80, t_lo = 10, c_hi = 100, c_lo = 20, v_hi = 150, v_lo = 50;
  logic [W-1:0] t_hy = 5, cv_hy = 10;
  logic comp = 0, mask_all = 0, clr = 0, peak = 0, link = 0;
  logic [3:0] emask = 0;
  logic [1:0] qsel = 0;
  logic alert_n;
  logic [5:0] status;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alert_ctrl #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .meas_valid_i(meas),
    .temp_i(t), .curr_i(c), .volt_i(v),
    .temp_hi_i(t_hi), .temp_lo_i(t_lo), .curr_hi_i(c_hi), .curr_lo_i(c_lo),
    .volt_hi_i(v_hi), .volt_lo_i(v_lo), .temp_hyst_i(t_hy), .cv_hyst_i(cv_hy),
    .comp_mode_i(comp), .mask_all_i(mask_all), .evt_mask_i(emask),
    .queue_sel_i(qsel), .status_clr_i(clr), .peak_i(peak), .peak_link_i(link),
    .alert_no(alert_n), .status_o(status)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reading applied for one edge, then settle one more edge
  task automatic rd(input logic [W-1:0] tv, input logic [W-1:0] cvv, input logic [W-1:0] vv);
    @(negedge clk); t = tv; c = cvv; v = vv; meas = 1;
    @(negedge clk); meas = 0;
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic clean();
    rd(40, 50, 100);
    ack();
  endtask

  task automatic t_reset();
    chk("R1 alert after reset", {7'd0, alert_n}, 8'd1);
    chk("R1 status after reset", {2'd0, status}, 8'd0);
  endtask

  task automatic t_queue();
    qsel = 1;
    rd(90, 50, 100);
    chk("R2 depth2 first reading", {2'd0, status}, 8'd0);
    chk("R2 depth2 alert idle", {7'd0, alert_n}, 8'd1);
    rd(90, 50, 100);
    chk("R2 depth2 second reading", {2'd0, status}, 8'h01);
    chk("R2 depth2 alert", {7'd0, alert_n}, 8'd0);
    clean();
    qsel = 2;
    rd(90, 50, 100); rd(90, 50, 100); rd(40, 50, 100);
    rd(90, 50, 100); rd(90, 50, 100); rd(90, 50, 100);
    chk("R2 depth4 run broken", {2'd0, status}, 8'd0);
    rd(90, 50, 100);
    chk("R2 depth4 fourth reading", {2'd0, status}, 8'h01);
    clean();
    qsel = 0;
    rd(80, 50, 100);
    chk("R2 equal high no fault", {2'd0, status}, 8'd0);
    rd(5, 50, 100);
    chk("R2 temp low fault", {2'd0, status}, 8'h02);
    clean();
  endtask

  task automatic t_cv();
    rd(40, 100, 150);
    chk("R3 equal limits no fault", {2'd0, status}, 8'd0);
    chk("R3 equal limits alert idle", {7'd0, alert_n}, 8'd1);
    rd(40, 101, 49);
    chk("R3 curr high volt low", {2'd0, status}, 8'h24);
    chk("R3 alert asserted", {7'd0, alert_n}, 8'd0);
    clean();
    chk("R3 cleared", {2'd0, status}, 8'd0);
  endtask

  task automatic t_latch();
    rd(90, 50, 100);
    ack();
    chk("R4 clear while fault present", {2'd0, status}, 8'h01);
    chk("R4 alert held", {7'd0, alert_n}, 8'd0);
    rd(40, 50, 100);
    chk("R4 latched after fault gone", {2'd0, status}, 8'h01);
    chk("R4 alert latched", {7'd0, alert_n}, 8'd0);
    ack();
    chk("R4 status cleared", {2'd0, status}, 8'd0);
    chk("R4 alert released", {7'd0, alert_n}, 8'd1);
  endtask

  task automatic t_mask();
    mask_all = 1;
    rd(40, 101, 100);
    chk("R5 status updates under mask", {2'd0, status}, 8'h04);
    chk("R5 alert masked", {7'd0, alert_n}, 8'd1);
    mask_all = 0; settle();
    chk("R5 alert after unmask", {7'd0, alert_n}, 8'd0);
    clean();
  endtask

  task automatic t_peak_int();
    link = 1; peak = 1; settle();
    chk("R6 peak ignored in interrupt mode", {7'd0, alert_n}, 8'd1);
    peak = 0; link = 0; settle();
  endtask

  task automatic t_comp_temp();
    comp = 1;
    rd(79, 50, 100);
    chk("R7 below high idle", {2'd0, status}, 8'd0);
    rd(80, 50, 100);
    chk("R7 at high active", {2'd0, status}, 8'h01);
    chk("R7 alert", {7'd0, alert_n}, 8'd0);
    ack();
    chk("R9 read does not clear", {2'd0, status}, 8'h01);
    rd(75, 50, 100);
    chk("R7 at threshold holds", {2'd0, status}, 8'h01);
    rd(74, 50, 100);
    chk("R9 auto clear on release", {2'd0, status}, 8'd0);
    chk("R7 alert released", {7'd0, alert_n}, 8'd1);
  endtask

  task automatic t_comp_cv();
    rd(40, 100, 150);
    chk("R8 curr volt active", {2'd0, status}, 8'h14);
    rd(40, 91, 140);
    chk("R8 above threshold holds", {2'd0, status}, 8'h14);
    rd(40, 89, 139);
    chk("R8 released", {2'd0, status}, 8'd0);
    chk("R8 alert released", {7'd0, alert_n}, 8'd1);
  endtask

  task automatic t_comp_mask();
    mask_all = 1;
    rd(85, 50, 100);
    chk("R10 global mask ignored", {7'd0, alert_n}, 8'd0);
    emask = 4'b0001; settle();
    chk("R10 per-event mask gates", {7'd0, alert_n}, 8'd1);
    chk("R10 status kept when masked", {2'd0, status}, 8'h01);
    emask = 0;
    rd(40, 50, 100);
    mask_all = 0; settle();
  endtask

  task automatic t_low_comp();
    rd(5, 50, 100);
    chk("R11 low latched in comparator", {2'd0, status}, 8'h02);
    rd(40, 50, 100);
    chk("R11 low stays latched", {2'd0, status}, 8'h02);
    chk("R11 alert from low", {7'd0, alert_n}, 8'd0);
    ack();
    chk("R11 low cleared by ack", {2'd0, status}, 8'd0);
    mask_all = 1;
    rd(40, 50, 40);
    chk("R11 low status under mask", {2'd0, status}, 8'h20);
    chk("R11 global mask blocks low", {7'd0, alert_n}, 8'd1);
    mask_all = 0;
    clean();
  endtask

  task automatic t_peak_comp();
    link = 1; peak = 1; settle();
    chk("R12 linked peak asserts", {7'd0, alert_n}, 8'd0);
    link = 0; settle();
    chk("R12 unlinked peak idle", {7'd0, alert_n}, 8'd1);
    link = 1; emask = 4'b1000; settle();
    chk("R10 peak masked", {7'd0, alert_n}, 8'd1);
    emask = 0; peak = 0; settle();
    chk("R12 peak gone", {7'd0, alert_n}, 8'd1);
    link = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_queue();
    t_cv();
    t_latch();
    t_mask();
    t_peak_int();
    t_comp_temp();
    t_comp_cv();
    t_comp_mask();
    t_low_comp();
    t_peak_comp();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule